// File: doc/BRIEF.md
# Two-Register Eight-Bit Datapath

This block is a small datapath with two general registers. Each register can copy its value onto either or both of two operand ports, A and B. A shared result bus feeds both registers. Only one of four sources drives it at a time: the external input, an adder/subtractor, a one-place shifter, or a bitwise logic unit. The logic unit's function comes from a four-bit truth table. A register captures the bus on a rising clock edge while its write strobe is high. While the read enable is high, the output shows operand port A.

A controller uses the block by raising one source enable, routing registers onto the ports and pulsing the write strobe of the destination register. It then routes that register to port A with the read enable high to see the result. No opcode is decoded. The bus source is chosen by a fixed priority over the enable strobes. If no enable is high, the bus is zero. The source decode has five named outcomes: none, external, arithmetic, shift and logic.

Top module: `dp8_two_reg`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) clears both registers to 0x00.
- R2: With ext_in_en high, the bus carries din, and a register whose write strobe is high at a rising edge captures it. A register whose strobe is low keeps its value.
- R3: For each register, routing bit 0 copies it onto port A and bit 1 copies it onto port B. A port is the bitwise OR of the registers routed to it, and 0x00 when none is routed.
- R4: While out_en is high, dout equals port A. While out_en is low, dout is 0x00.
- R5: With add_en high and sub_mode low, the bus is port A plus port B, modulo 256.
- R6: With add_en high and sub_mode high, the bus is port A minus port B, modulo 256 (A plus the inverse of B plus one).
- R7: With shf_en high, port A is shifted one place and the vacated bit is filled with zero. The shift is right when shf_left is low and left when it is high.
- R8: With lgc_en high, result bit i is lgc_tt[{a_i, b_i}], where a is port A and b is port B. Code 0110 gives XOR, 1000 gives AND, 1110 gives OR and 0000 gives zero.
- R9: The bus source priority is ext_in_en, then add_en, then shf_en, then lgc_en.
- R10: With no source enable high, the bus is 0x00, so a write strobe clears its register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 8 | External data |
| ext_in_en | input | 1 | Drive din onto the bus |
| wr_r0 | input | 1 | Write strobe for register 0 |
| wr_r1 | input | 1 | Write strobe for register 1 |
| rt_r0 | input | 2 | Register 0 routing: bit 0 to port A, bit 1 to port B |
| rt_r1 | input | 2 | Register 1 routing: bit 0 to port A, bit 1 to port B |
| out_en | input | 1 | Show port A on dout |
| add_en | input | 1 | Adder/subtractor drives the bus |
| sub_mode | input | 1 | Carry-in: high selects subtraction |
| shf_en | input | 1 | Shifter drives the bus |
| shf_left | input | 1 | Shift direction: high is left |
| lgc_en | input | 1 | Logic unit drives the bus |
| lgc_tt | input | 4 | Logic unit truth table |
| dout | output | 8 | Datapath output |

## Verification
The bench checks wrap-around at both ends. 0xFF plus 0x01 must give zero, and 0x00 minus 0x01 must give 0xFF. An adder with a wrong carry-in, or a subtractor missing its increment, is off by one in these cases. The bench shifts values with both end bits set, so a shifter that rotates, or that fills from the wrong side, gives a visibly wrong byte. It feeds several truth-table codes with 0xF0 and 0x3C, which together hold all four bit pairs. A table indexed as {b,a} instead of {a,b} fails on the asymmetric codes. The bench also raises several source enables at once, and writes while no enable is high. A priority that is reversed, or a bus that floats, stores the wrong source or a stale value.

// File: rtl/dp8_pkg.sv
package dp8_pkg;
    // Which unit owns the shared result bus in a given cycle.
    typedef enum logic [2:0] {
        SRC_NONE  = 3'd0,
        SRC_EXT   = 3'd1,
        SRC_ARITH = 3'd2,
        SRC_SHIFT = 3'd3,
        SRC_LOGIC = 3'd4
    } bus_src_e;

    localparam int ROUTE_BITS = 2;
endpackage

// File: rtl/dp8_regfile.sv
module dp8_regfile
    import dp8_pkg::*;
#(
    parameter int W    = 8,
    parameter int NREG = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NREG-1:0]            wr,
    input  logic [NREG*ROUTE_BITS-1:0] route,
    input  logic [W-1:0]               bus,
    output logic [W-1:0]               port_a,
    output logic [W-1:0]               port_b
);
    logic [W-1:0] q [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)        q[i] <= '0;
            else if (wr[i]) q[i] <= bus;
        end

        // R1: reset clears every register
        a_r1_reset_clears: assert property (@(posedge clk) rst |=> q[i] == '0);
        // R2: a strobed register takes the bus value
        a_r2_capture: assert property (@(posedge clk) disable iff (rst)
            wr[i] |=> q[i] == $past(bus));
        // R2: an unstrobed register holds its value
        a_r2_hold: assert property (@(posedge clk) disable iff (rst)
            !wr[i] |=> $stable(q[i]));
    end

    // R3: each port is the OR of the registers routed onto it
    always_comb begin
        port_a = '0;
        port_b = '0;
        for (int k = 0; k < NREG; k++) begin
            if (route[ROUTE_BITS*k])     port_a = port_a | q[k];
            if (route[ROUTE_BITS*k + 1]) port_b = port_b | q[k];
        end
    end

    // R3: a port with nothing routed to it reads zero
    always_comb begin
        if (route == '0) a_r3_unrouted_zero: assert ((port_a | port_b) == '0);
    end
endmodule

// File: rtl/dp8_units.sv
module dp8_units #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub_mode,
    input  logic         shf_left,
    input  logic [3:0]   tt,
    output logic [W-1:0] sum,
    output logic [W-1:0] shifted,
    output logic [W-1:0] logic_out
);
    logic [W-1:0] b_eff;

    // R5, R6: the carry-in both inverts B and adds the one
    assign b_eff = sub_mode ? ~b : b;
    assign sum   = a + b_eff + {{(W-1){1'b0}}, sub_mode};

    // R7: one-place shift with zero fill
    assign shifted = shf_left ? {a[W-2:0], 1'b0} : {1'b0, a[W-1:1]};

    // R8: a truth-table lookup per bit
    for (genvar i = 0; i < W; i++) begin : g_lut
        assign logic_out[i] = tt[{a[i], b[i]}];
    end

    always_comb begin
        // R5: removing B from the sum gives back A
        if (!sub_mode) a_r5_add_inverse: assert (W'(sum - b) == a);
        // R6: adding B back to the difference gives back A
        if (sub_mode)  a_r6_sub_inverse: assert (W'(sum + b) == a);
        // R7: the shift drops exactly the bit that falls off the end
        if (!shf_left) a_r7_right_ones: assert ($countones(shifted) == $countones(a) - int'(a[0]));
        if (shf_left)  a_r7_left_ones:  assert ($countones(shifted) == $countones(a) - int'(a[W-1]));
        // R8: code 0110 behaves as XOR
        if (tt == 4'b0110) a_r8_xor_code: assert (logic_out == (a ^ b));
    end
endmodule

// File: rtl/dp8_bus_arb.sv
module dp8_bus_arb
    import dp8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         ext_in_en,
    input  logic         add_en,
    input  logic         shf_en,
    input  logic         lgc_en,
    input  logic [W-1:0] din,
    input  logic [W-1:0] sum,
    input  logic [W-1:0] shifted,
    input  logic [W-1:0] logic_out,
    output bus_src_e     src,
    output logic [W-1:0] bus
);
    // R9: fixed priority decode of the source strobes
    always_comb begin
        if (ext_in_en)   src = SRC_EXT;
        else if (add_en) src = SRC_ARITH;
        else if (shf_en) src = SRC_SHIFT;
        else if (lgc_en) src = SRC_LOGIC;
        else             src = SRC_NONE;
    end

    always_comb begin
        unique case (src)
            SRC_EXT:   bus = din;
            SRC_ARITH: bus = sum;
            SRC_SHIFT: bus = shifted;
            SRC_LOGIC: bus = logic_out;
            default:   bus = '0;
        endcase
    end

    always_comb begin
        // R2, R9: the external input wins over every unit
        if (ext_in_en) a_r9_ext_first: assert (bus == din);
        // R9: the arithmetic unit outranks the shifter and the logic unit
        if (!ext_in_en && add_en) a_r9_arith_second: assert (bus == sum);
        // R10: an idle bus reads zero
        if (!(ext_in_en || add_en || shf_en || lgc_en)) a_r10_idle_bus: assert (bus == '0);
    end
endmodule

// File: rtl/dp8_two_reg.sv
module dp8_two_reg
    import dp8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    input  logic         ext_in_en,
    input  logic         wr_r0,
    input  logic         wr_r1,
    input  logic [1:0]   rt_r0,
    input  logic [1:0]   rt_r1,
    input  logic         out_en,
    input  logic         add_en,
    input  logic         sub_mode,
    input  logic         shf_en,
    input  logic         shf_left,
    input  logic         lgc_en,
    input  logic [3:0]   lgc_tt,
    output logic [W-1:0] dout
);
    localparam int NREG = 2;

    logic [W-1:0] port_a, port_b, bus;
    logic [W-1:0] sum, shifted, logic_out;
    bus_src_e     src;

    dp8_regfile #(.W(W), .NREG(NREG)) u_rf (
        .clk    (clk),
        .rst    (rst),
        .wr     ({wr_r1, wr_r0}),
        .route  ({rt_r1, rt_r0}),
        .bus    (bus),
        .port_a (port_a),
        .port_b (port_b)
    );

    dp8_units #(.W(W)) u_units (
        .a         (port_a),
        .b         (port_b),
        .sub_mode  (sub_mode),
        .shf_left  (shf_left),
        .tt        (lgc_tt),
        .sum       (sum),
        .shifted   (shifted),
        .logic_out (logic_out)
    );

    dp8_bus_arb #(.W(W)) u_arb (
        .ext_in_en (ext_in_en),
        .add_en    (add_en),
        .shf_en    (shf_en),
        .lgc_en    (lgc_en),
        .din       (din),
        .sum       (sum),
        .shifted   (shifted),
        .logic_out (logic_out),
        .src       (src),
        .bus       (bus)
    );

    // R4: the output is gated by the read enable
    assign dout = out_en ? port_a : '0;

    // R2, R4: a loaded value can be read back on the next cycle
    a_r4_readback: assert property (@(posedge clk) disable iff (rst)
        (ext_in_en && wr_r0 && !wr_r1)
        |=> (!(out_en && rt_r0 == 2'b01 && rt_r1 == 2'b00) || dout == $past(din)));
endmodule

// File: tb/sim_dp8_two_reg.sv
module sim_dp8_two_reg;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] din = '0;
    logic       ext_in_en = 0, wr_r0 = 0, wr_r1 = 0, out_en = 0;
    logic [1:0] rt_r0 = '0, rt_r1 = '0;
    logic       add_en = 0, sub_mode = 0, shf_en = 0, shf_left = 0, lgc_en = 0;
    logic [3:0] lgc_tt = '0;
    logic [7:0] dout;
    int         n_run = 0, n_fail = 0;

    always #10 clk = ~clk;  // 50 MHz

    dp8_two_reg u0 (
        .clk(clk), .rst(rst), .din(din), .ext_in_en(ext_in_en),
        .wr_r0(wr_r0), .wr_r1(wr_r1), .rt_r0(rt_r0), .rt_r1(rt_r1),
        .out_en(out_en), .add_en(add_en), .sub_mode(sub_mode),
        .shf_en(shf_en), .shf_left(shf_left), .lgc_en(lgc_en),
        .lgc_tt(lgc_tt), .dout(dout)
    );

    // Vector: a[31:24] b[23:16] op[15:14] (0 arith, 1 shift, 2 logic)
    //         ctl[13] (sub_mode or shf_left) tt[11:8] expected[7:0]
    localparam int NV = 18;
    localparam logic [31:0] VEC [NV] = '{
        32'h837F_0002,  // R5 add wraps to 0x02
        32'hFF01_0000,  // R5 add wraps to zero
        32'h1234_0046,  // R5 plain add
        32'h0503_2002,  // R6 subtract
        32'h0001_20FF,  // R6 borrow wrap
        32'h7F80_20FF,  // R6 subtract across sign
        32'h0200_4001,  // R7 right
        32'h8100_4040,  // R7 right zero fill
        32'h8100_6002,  // R7 left zero fill
        32'h7F00_60FE,  // R7 left
        32'h017F_867E,  // R8 xor
        32'hF03C_8830,  // R8 and
        32'hF03C_8EFC,  // R8 or
        32'hA55A_8000,  // R8 zero
        32'hA55A_8FFF,  // R8 one
        32'hF03C_84C0,  // R8 a and not b
        32'hF03C_8A3C,  // R8 pass b
        32'hF03C_8CF0   // R8 pass a
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic clear_ctl();
        ext_in_en = 0; wr_r0 = 0; wr_r1 = 0; out_en = 0; rt_r0 = 0; rt_r1 = 0;
        add_en = 0; sub_mode = 0; shf_en = 0; shf_left = 0; lgc_en = 0; lgc_tt = 0;
    endtask

    // Called at a falling edge; the write lands at the next rising edge.
    task automatic load(input int r, input logic [7:0] v);
        din = v; ext_in_en = 1; wr_r0 = (r == 0); wr_r1 = (r == 1);
        @(negedge clk);
        clear_ctl();
    endtask

    task automatic peek(input logic [1:0] ra, input logic [1:0] rb, output logic [7:0] v);
        rt_r0 = ra; rt_r1 = rb; out_en = 1;
        #2 v = dout;
        clear_ctl();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: both registers read zero after reset
        peek(2'b01, 2'b00, v); check("R1 r0 after reset", v, 8'h00);
        peek(2'b00, 2'b01, v); check("R1 r1 after reset", v, 8'h00);

        // Table of operations: r0 on port A, r1 on port B, result into r0
        for (int i = 0; i < NV; i++) begin
            load(0, VEC[i][31:24]);
            load(1, VEC[i][23:16]);
            rt_r0 = 2'b01; rt_r1 = 2'b10; wr_r0 = 1;
            lgc_tt = VEC[i][11:8];
            case (VEC[i][15:14])
                2'd0:    begin add_en = 1; sub_mode = VEC[i][13]; end
                2'd1:    begin shf_en = 1; shf_left = VEC[i][13]; end
                default: lgc_en = 1;
            endcase
            @(negedge clk);
            clear_ctl();
            peek(2'b01, 2'b00, v);
            check($sformatf("R5/R6/R7/R8 vector %0d", i), v, VEC[i][7:0]);
        end

        // R2: loading r1 leaves r0 alone
        load(0, 8'h5A); load(1, 8'hC3);
        peek(2'b01, 2'b00, v); check("R2 r0 holds", v, 8'h5A);
        peek(2'b00, 2'b01, v); check("R2 r1 loaded", v, 8'hC3);
        // R4: dout is zero while out_en is low
        rt_r0 = 2'b01; #2 check("R4 out_en low", dout, 8'h00); clear_ctl();
        // R3: both registers on port A combine by OR; nothing routed reads zero
        load(0, 8'h0F); load(1, 8'hF0);
        peek(2'b01, 2'b01, v); check("R3 or on port A", v, 8'hFF);
        peek(2'b00, 2'b00, v); check("R3 unrouted", v, 8'h00);
        // R3/R6: swapped routing, r1 on A and r0 on B: 0xF0 - 0x0F
        rt_r0 = 2'b10; rt_r1 = 2'b01; add_en = 1; sub_mode = 1; wr_r1 = 1;
        @(negedge clk); clear_ctl();
        peek(2'b00, 2'b01, v); check("R3 swapped subtract", v, 8'hE1);
        // R9: external input outranks arithmetic
        load(0, 8'h11); load(1, 8'h22);
        rt_r0 = 2'b01; rt_r1 = 2'b10; din = 8'h99; ext_in_en = 1; add_en = 1; wr_r0 = 1;
        @(negedge clk); clear_ctl();
        peek(2'b01, 2'b00, v); check("R9 ext over add", v, 8'h99);
        // R9: arithmetic outranks shift: 0x99 + 0x22
        rt_r0 = 2'b01; rt_r1 = 2'b10; add_en = 1; shf_en = 1; wr_r0 = 1;
        @(negedge clk); clear_ctl();
        peek(2'b01, 2'b00, v); check("R9 add over shift", v, 8'hBB);
        // R9: shift outranks logic: 0xBB >> 1
        rt_r0 = 2'b01; rt_r1 = 2'b10; shf_en = 1; lgc_en = 1; lgc_tt = 4'b1111; wr_r0 = 1;
        @(negedge clk); clear_ctl();
        peek(2'b01, 2'b00, v); check("R9 shift over logic", v, 8'h5D);
        // R10: write with no source clears the register
        wr_r1 = 1;
        @(negedge clk); clear_ctl();
        peek(2'b00, 2'b01, v); check("R10 idle write", v, 8'h00);
        // R1: reset clears previously loaded values
        load(0, 8'hAB); load(1, 8'hCD);
        rst = 1; @(negedge clk); rst = 0;
        peek(2'b01, 2'b00, v); check("R1 r0 cleared", v, 8'h00);
        peek(2'b00, 2'b01, v); check("R1 r1 cleared", v, 8'h00);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule